// File: doc/BRIEF.md
# Masked Fast/Normal Interrupt Request Router

This block collects sixteen interrupt sources into one status word and gates them with a mask that software can write. It drives two request lines toward a processor core. The fast request line (FIQ) serves four fixed sources. The normal request line (IRQ) serves the other twelve. A small vector output names the entry address of the request that wins.

One of the sixteen status positions belongs to a keyboard latch inside the block. The latch sets when any selected parallel-port input is high. A configuration bit chooses whether six or eight port inputs are watched. Once set, the latch stays set until software writes to a dedicated end-of-interrupt location. The other fifteen positions come from external source pins. These are registered once before they reach the status word.

Software reaches the block through a simple word-addressed register bus with separate read and write strobes. Read data is registered. The register offsets are:
- 0x0: status (read only).
- 0x4: mask (read/write).
- 0x8: keyboard end-of-interrupt (write only).
- 0xC: keyboard configuration.

Top module: `int_mask_router`

## Requirements
- R1: After a synchronous reset, fiq_o, irq_o, vec_o and bus_rdata_o are all zero, the mask reads as zero, the keyboard configuration reads as zero and the keyboard latch is clear.
- R2: A read strobe at offset 0x0 places the status word in bus_rdata_o[15:0] on the next cycle, with bits 31:16 zero. Each status bit is 1 while its source is active, whatever the mask. A change on src_i shows in status one cycle after it is sampled.
- R3: The mask at offset 0x4 takes bus_wdata_i[15:0] on a write and reads back on bus_rdata_o[15:0]. Bits 31:16 read as zero and ignore writes.
- R4: fiq_o is 1 exactly when some status bit among bits 3:0 is set together with its mask bit. It follows a mask write on the cycle after the write.
- R5: irq_o is 1 exactly when some status bit among bits 15:4 is set together with its mask bit.
- R6: vec_o is 0x1C while fiq_o is 1. It is 0x18 while irq_o is 1 and fiq_o is 0. It is 0x00 when neither is set. The fast request takes priority.
- R7: Configuration bit 0 at offset 0xC selects the keyboard inputs. When it is 0, only port_i[5:0] can set the latch and port_i[7:6] are ignored. When it is 1, all of port_i[7:0] can set it. The bit reads back in bus_rdata_o[0].
- R8: A selected port input that is high for a single cycle sets the keyboard latch. The latch then holds until a write (any data) to offset 0x8 clears it.
- R9: If an end-of-interrupt write and a selected port input fall in the same cycle, the latch stays set.
- R10: Status bit 4 is the keyboard latch. Status bits 3:0 are src_i[3:0], and status bits 15:5 are src_i[14:4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_i | input | 15 | External interrupt sources, active high |
| port_i | input | 8 | Parallel port inputs feeding the keyboard latch |
| bus_rd_i | input | 1 | Register read strobe |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Byte address of the register (bits 3:2 select) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |
| vec_o | output | 8 | Entry address of the winning request, zero when idle |

## Verification
Two functions can fall in the same cycle. A key press can coincide with the end-of-interrupt write that clears the keyboard latch. A fast source and a normal source can also be pending and enabled together. The bench holds a low port input high during the clearing write, and judges through irq_o and a status read that the latch survived. It also enables one fast source and one normal source at once and checks that both lines assert while the vector shows the fast entry.

// File: rtl/int_router_pkg.sv
package int_router_pkg;

    // Register select, taken from byte address bits 3:2
    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_KEOI   = 2'd2,
        SEL_KCFG   = 2'd3
    } reg_sel_e;

    localparam int unsigned SEL_LSB = 2;

endpackage

// File: rtl/int_regbank.sv
module int_regbank
    import int_router_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_i,
    input  logic               wr_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic [NUM_SRC-1:0] status_i,
    output logic [NUM_SRC-1:0] mask_o,
    output logic               all8_o,
    output logic               eoi_o,
    output logic [DATA_W-1:0]  rdata_o
);

    localparam int unsigned PAD_W = DATA_W - NUM_SRC;

    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
        logic               all8;
        logic [DATA_W-1:0]  rdata;
    } bank_t;

    bank_t    bank_d, bank_q;
    reg_sel_e sel;

    logic unused_bits;
    assign unused_bits = ^{wdata_i[DATA_W-1:NUM_SRC], addr_i[SEL_LSB-1:0]};

    assign sel = reg_sel_e'(addr_i[SEL_LSB +: 2]);

    always_comb begin
        bank_d = bank_q;
        if (wr_i) begin
            case (sel)
                SEL_MASK: bank_d.mask = wdata_i[NUM_SRC-1:0];
                SEL_KCFG: bank_d.all8 = wdata_i[0];
                default:  ;
            endcase
        end
        if (rd_i) begin
            case (sel)
                SEL_STATUS: bank_d.rdata = {{PAD_W{1'b0}}, status_i};
                SEL_MASK:   bank_d.rdata = {{PAD_W{1'b0}}, bank_q.mask};
                SEL_KCFG:   bank_d.rdata = {{(DATA_W-1){1'b0}}, bank_q.all8};
                default:    bank_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign mask_o  = bank_q.mask;
    assign all8_o  = bank_q.all8;
    assign rdata_o = bank_q.rdata;
    assign eoi_o   = wr_i && (sel == SEL_KEOI);

endmodule

// File: rtl/kbd_latch.sv
module kbd_latch #(
    parameter int unsigned PORT_W     = 8,
    parameter int unsigned KBD_NARROW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] port_i,
    input  logic              all8_i,
    input  logic              eoi_i,
    output logic              press_o,
    output logic              latched_o
);

    typedef struct packed {
        logic lat;
    } kbd_t;

    kbd_t              kbd_d, kbd_q;
    logic [PORT_W-1:0] in_en;

    for (genvar gi = 0; gi < PORT_W; gi++) begin : g_en
        if (gi < KBD_NARROW) begin : g_lo
            assign in_en[gi] = 1'b1;
        end else begin : g_hi
            assign in_en[gi] = all8_i;
        end
    end

    assign press_o = |(port_i & in_en);

    // A press in the same cycle as the clear keeps the latch set
    always_comb begin
        kbd_d     = kbd_q;
        kbd_d.lat = press_o | (kbd_q.lat & ~eoi_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kbd_q <= '0;
        end else begin
            kbd_q <= kbd_d;
        end
    end

    assign latched_o = kbd_q.lat;

endmodule

// File: rtl/req_router.sv
module req_router #(
    parameter int unsigned NUM_SRC  = 16,
    parameter int unsigned NUM_FAST = 4,
    parameter int unsigned KBD_IDX  = 4,
    parameter int unsigned VEC_W    = 8,
    parameter int unsigned FIQ_VEC  = 'h1C,
    parameter int unsigned IRQ_VEC  = 'h18
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-2:0] src_i,
    input  logic               kbd_i,
    input  logic [NUM_SRC-1:0] mask_i,
    output logic [NUM_SRC-1:0] status_o,
    output logic               fiq_o,
    output logic               irq_o,
    output logic [VEC_W-1:0]   vec_o
);

    typedef struct packed {
        logic [NUM_SRC-2:0] src;
    } rt_t;

    rt_t rt_d, rt_q;

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_stat
        if (gi < KBD_IDX) begin : g_below
            assign status_o[gi] = rt_q.src[gi];
        end else if (gi == KBD_IDX) begin : g_kbd
            assign status_o[gi] = kbd_i;
        end else begin : g_above
            assign status_o[gi] = rt_q.src[gi-1];
        end
    end

    always_comb begin
        rt_d     = rt_q;
        rt_d.src = src_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rt_q <= '0;
        end else begin
            rt_q <= rt_d;
        end
    end

    assign fiq_o = |(status_o[NUM_FAST-1:0] & mask_i[NUM_FAST-1:0]);
    assign irq_o = |(status_o[NUM_SRC-1:NUM_FAST] & mask_i[NUM_SRC-1:NUM_FAST]);

    always_comb begin
        if (fiq_o) begin
            vec_o = VEC_W'(FIQ_VEC);
        end else if (irq_o) begin
            vec_o = VEC_W'(IRQ_VEC);
        end else begin
            vec_o = '0;
        end
    end

endmodule

// File: rtl/int_mask_router.sv
module int_mask_router #(
    parameter int unsigned NUM_SRC    = 16,
    parameter int unsigned NUM_FAST   = 4,
    parameter int unsigned KBD_IDX    = 4,
    parameter int unsigned PORT_W     = 8,
    parameter int unsigned KBD_NARROW = 6,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned VEC_W      = 8,
    parameter int unsigned FIQ_VEC    = 'h1C,
    parameter int unsigned IRQ_VEC    = 'h18
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-2:0] src_i,
    input  logic [PORT_W-1:0]  port_i,
    input  logic               bus_rd_i,
    input  logic               bus_wr_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic               fiq_o,
    output logic               irq_o,
    output logic [VEC_W-1:0]   vec_o
);

    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] status_w;
    logic               cfg_all8;
    logic               kbd_eoi;
    logic               kbd_press;
    logic               kbd_lat;

    int_regbank #(
        .NUM_SRC (NUM_SRC),
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .rd_i     (bus_rd_i),
        .wr_i     (bus_wr_i),
        .addr_i   (bus_addr_i),
        .wdata_i  (bus_wdata_i),
        .status_i (status_w),
        .mask_o   (mask_q),
        .all8_o   (cfg_all8),
        .eoi_o    (kbd_eoi),
        .rdata_o  (bus_rdata_o)
    );

    kbd_latch #(
        .PORT_W     (PORT_W),
        .KBD_NARROW (KBD_NARROW)
    ) u_kbd (
        .clk       (clk),
        .rst       (rst),
        .port_i    (port_i),
        .all8_i    (cfg_all8),
        .eoi_i     (kbd_eoi),
        .press_o   (kbd_press),
        .latched_o (kbd_lat)
    );

    req_router #(
        .NUM_SRC  (NUM_SRC),
        .NUM_FAST (NUM_FAST),
        .KBD_IDX  (KBD_IDX),
        .VEC_W    (VEC_W),
        .FIQ_VEC  (FIQ_VEC),
        .IRQ_VEC  (IRQ_VEC)
    ) u_route (
        .clk      (clk),
        .rst      (rst),
        .src_i    (src_i),
        .kbd_i    (kbd_lat),
        .mask_i   (mask_q),
        .status_o (status_w),
        .fiq_o    (fiq_o),
        .irq_o    (irq_o),
        .vec_o    (vec_o)
    );

endmodule

// File: rtl/int_mask_router_chk.sv
module int_mask_router_chk #(
    parameter int unsigned NUM_SRC  = 16,
    parameter int unsigned NUM_FAST = 4,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned VEC_W    = 8,
    parameter int unsigned FIQ_VEC  = 'h1C
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_rd_i,
    input logic [ADDR_W-1:0]  bus_addr_i,
    input logic [DATA_W-1:0]  bus_rdata_o,
    input logic               fiq_o,
    input logic               irq_o,
    input logic [VEC_W-1:0]   vec_o,
    input logic [NUM_SRC-1:0] mask_q,
    input logic               kbd_lat,
    input logic               kbd_press,
    input logic               kbd_eoi
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!fiq_o && !irq_o && vec_o == '0 && bus_rdata_o == '0));

    // R3
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_i && bus_addr_i[3:2] == 2'd1) |=> (bus_rdata_o[DATA_W-1:NUM_SRC] == '0));

    // R4
    fiq_needs_mask_chk: assert property (@(posedge clk) disable iff (rst)
        fiq_o |-> (mask_q[NUM_FAST-1:0] != '0));

    // R5
    irq_needs_mask_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (mask_q[NUM_SRC-1:NUM_FAST] != '0));

    // R6
    vec_fast_first_chk: assert property (@(posedge clk) disable iff (rst)
        fiq_o |-> (vec_o == VEC_W'(FIQ_VEC)));

    // R8
    kbd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (kbd_lat && !kbd_eoi) |=> kbd_lat);

    // R8
    kbd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (kbd_eoi && !kbd_press) |=> !kbd_lat);

    // R9
    kbd_press_wins_chk: assert property (@(posedge clk) disable iff (rst)
        kbd_press |=> kbd_lat);

endmodule

bind int_mask_router int_mask_router_chk #(
    .NUM_SRC  (NUM_SRC),
    .NUM_FAST (NUM_FAST),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .VEC_W    (VEC_W),
    .FIQ_VEC  (FIQ_VEC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_rd_i    (bus_rd_i),
    .bus_addr_i  (bus_addr_i),
    .bus_rdata_o (bus_rdata_o),
    .fiq_o       (fiq_o),
    .irq_o       (irq_o),
    .vec_o       (vec_o),
    .mask_q      (mask_q),
    .kbd_lat     (kbd_lat),
    .kbd_press   (kbd_press),
    .kbd_eoi     (kbd_eoi)
);

// File: tb/int_mask_router_tb.sv
module int_mask_router_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] src_i = '0;
    logic [7:0]  port_i = '0;
    logic        bus_rd_i = 1'b0;
    logic        bus_wr_i = 1'b0;
    logic [3:0]  bus_addr_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        fiq_o;
    logic        irq_o;
    logic [7:0]  vec_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        string       req;
        int          kind;   // 0 rdata, 1 fiq, 2 irq, 3 vec
        logic [31:0] exp;
    } sb_item_t;

    sb_item_t sb[$];
    event     chk_ev;

    always #4 clk = ~clk;

    int_mask_router u_dut (
        .clk         (clk),
        .rst         (rst),
        .src_i       (src_i),
        .port_i      (port_i),
        .bus_rd_i    (bus_rd_i),
        .bus_wr_i    (bus_wr_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .fiq_o       (fiq_o),
        .irq_o       (irq_o),
        .vec_o       (vec_o)
    );

    // Monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            @(chk_ev);
            while (sb.size() > 0) begin
                sb_item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0:       act = bus_rdata_o;
                    1:       act = {31'd0, fiq_o};
                    2:       act = {31'd0, irq_o};
                    default: act = {24'd0, vec_o};
                endcase
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s kind=%0d actual=0x%08h expected=0x%08h",
                             it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic push(input string req, input int kind, input logic [31:0] exp);
        sb_item_t it;
        it.req = req; it.kind = kind; it.exp = exp;
        sb.push_back(it);
    endtask

    task automatic flush();
        -> chk_ev;
        #1;
    endtask

    task automatic expect_req(input string req, input bit f, input bit i, input logic [7:0] v);
        push(req, 1, {31'd0, f});
        push(req, 2, {31'd0, i});
        push(req, 3, {24'd0, v});
        flush();
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
        tick();
        bus_wr_i = 1'b0;
    endtask

    task automatic bus_read_expect(input string req, input logic [3:0] a, input logic [31:0] exp);
        bus_addr_i = a; bus_rd_i = 1'b1;
        tick();
        bus_rd_i = 1'b0;
        push(req, 0, exp);
        flush();
    endtask

    task automatic pulse_port(input logic [7:0] p);
        port_i = p;
        tick();
        port_i = '0;
    endtask

    initial begin
        repeat (3) tick();
        // R1 reset state
        expect_req("R1", 1'b0, 1'b0, 8'h00);
        push("R1", 0, 32'h0); flush();
        rst = 1'b0;
        tick();
        bus_read_expect("R1", 4'h4, 32'h0);
        bus_read_expect("R1", 4'hC, 32'h0);

        // R3 mask write and read back, upper bits dropped
        bus_write(4'h4, 32'hFFFF_A5F0);
        bus_read_expect("R3", 4'h4, 32'h0000_A5F0);
        bus_write(4'h4, 32'h0000_0000);
        bus_read_expect("R3", 4'h4, 32'h0);

        // R2 and R10: status independent of mask; bit 4 is keyboard
        src_i = 15'h7FFF;
        tick();
        bus_read_expect("R2", 4'h0, 32'h0000_FFEF);
        expect_req("R2", 1'b0, 1'b0, 8'h00);
        src_i = 15'h0010;          // src_i[4] lands in status bit 5
        tick();
        bus_read_expect("R10", 4'h0, 32'h0000_0020);

        // R4 fast request
        src_i = 15'h0002;          // status bit 1
        tick();
        expect_req("R4", 1'b0, 1'b0, 8'h00);
        bus_write(4'h4, 32'h0000_0002);
        expect_req("R4", 1'b1, 1'b0, 8'h1C);
        bus_write(4'h4, 32'h0000_0001);
        expect_req("R4", 1'b0, 1'b0, 8'h00);

        // R5 normal request
        src_i = 15'h0200;          // src_i[9] -> status bit 10
        tick();
        bus_write(4'h4, 32'h0000_0400);
        expect_req("R5", 1'b0, 1'b1, 8'h18);
        bus_write(4'h4, 32'h0000_0800);
        expect_req("R5", 1'b0, 1'b0, 8'h00);

        // R6 both pending: fast wins the vector
        src_i = 15'h0202;
        tick();
        bus_write(4'h4, 32'h0000_0402);
        expect_req("R6", 1'b1, 1'b1, 8'h1C);
        src_i = 15'h0;
        tick();
        expect_req("R6", 1'b0, 1'b0, 8'h00);
        bus_write(4'h4, 32'h0000_FFFF);
        bus_read_expect("R2", 4'h0, 32'h0);

        // R7 narrow selection ignores port bits 7:6
        pulse_port(8'hC0);
        expect_req("R7", 1'b0, 1'b0, 8'h00);
        bus_read_expect("R7", 4'h0, 32'h0);

        // R8 single-cycle pulse sets the latch, which holds
        pulse_port(8'h20);
        expect_req("R8", 1'b0, 1'b1, 8'h18);
        repeat (3) tick();
        expect_req("R8", 1'b0, 1'b1, 8'h18);
        bus_read_expect("R10", 4'h0, 32'h0000_0010);
        bus_write(4'h8, 32'h0);
        expect_req("R8", 1'b0, 1'b0, 8'h00);

        // R7 wide selection
        bus_write(4'hC, 32'h0000_0001);
        bus_read_expect("R7", 4'hC, 32'h0000_0001);
        pulse_port(8'h80);
        expect_req("R7", 1'b0, 1'b1, 8'h18);

        // R9 press during clear keeps latch set
        port_i = 8'h01;
        bus_write(4'h8, 32'h0);
        port_i = '0;
        expect_req("R9", 1'b0, 1'b1, 8'h18);
        bus_read_expect("R9", 4'h0, 32'h0000_0010);
        bus_write(4'h8, 32'h0);
        expect_req("R9", 1'b0, 1'b0, 8'h00);

        tick();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule